// File: doc/BRIEF.md
# Cascaded Display RAM Write Controller

This block turns a stream of display data bytes into single-bit writes for a display RAM that holds four rows per column address. Each accepted byte is unpacked most significant bit first, one bit per clock cycle. Every bit lands in one row of the current column. The number of bits each column takes depends on the drive mode: one in static mode, two in 1:2, three in 1:3 and four in 1:4. Once a column has its full group of bits, the column pointer moves on. A group of bits may straddle two bytes.

Several identical devices can share one serial bus and split a single long data stream between them. Each device keeps a 3-bit subaddress counter and compares it with its strapped hardware subaddress. Only a device whose counter matches its pins raises its write enable. Every device still steps its pointer as if it had written. When the pointer runs past the last column, it wraps to zero and the subaddress counter increments. The stream therefore spills over to the next device, even in the middle of a byte. An input bank setting moves static-mode and 1:2-mode data into the upper rows, so a second image can be built there.

Top module: `disp_ram_writer`

## Requirements
- R1: After reset, the write enable is low, the column pointer is 0, the subaddress counter is 0 and the row phase is 0.
- R2: A byte sampled with `byte_valid` at clock edge E0 produces one write cycle per bit, most significant bit first. Bit n (n=0 is bit 7) is presented on the outputs after edge E(n+1). `wr_mask` is one-hot on the target row (bit k = row k), `wr_data` carries the bit value in that row position only, and `wr_en` is low when no bit is being presented.
- R3: Static mode (`drive_mode`=0) writes each bit to row 0 and advances the column after every bit.
- R4: In 1:2 mode (`drive_mode`=1), consecutive bits go to rows 0 and 1 of a column, and then the column advances.
- R5: In 1:3 mode (`drive_mode`=2), bits fill rows 0, 1 and 2 before the column advances, and the row phase carries from one byte to the next.
- R6: In 1:4 mode (`drive_mode`=3), bits fill rows 0 to 3 before the column advances.
- R7: With `in_bank`=1, static mode writes row 2 and 1:2 mode writes rows 2 and 3. In 1:3 and 1:4 modes, `in_bank` has no effect.
- R8: When the subaddress counter differs from `hw_sub`, `wr_en` stays low for that bit. The pointer and row phase still advance exactly as for a real write.
- R9: When the last column (COLS-1) completes, the pointer wraps to 0 and the subaddress counter increments. Later bits of the same byte use the new counter value.
- R10: The subaddress counter wraps from 7 to 0.
- R11: `dev_sel` loads the subaddress counter from `dev_val`. `ptr_load` sets the column from `ptr_val` and restarts the row phase at the first row.
- R12: A pointer load with a value of COLS or above sets the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_sub | input | 3 | Strapped hardware subaddress |
| dev_sel | input | 1 | Load subaddress counter strobe |
| dev_val | input | 3 | Subaddress counter load value |
| ptr_load | input | 1 | Load column pointer strobe |
| ptr_val | input | 7 | Column pointer load value |
| drive_mode | input | 2 | 0 static, 1 1:2, 2 1:3, 3 1:4 |
| in_bank | input | 1 | Input bank select |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | 7 | RAM column address |
| wr_mask | output | 4 | One-hot row mask |
| wr_data | output | 4 | Write data aligned to the mask |

## Verification
The assertions assume three things about the inputs. Bytes arrive at least eight cycles apart, so a byte is never loaded while the previous one is still being unpacked. Drive mode and bank select hold steady while a byte is in flight. Commands are issued only while the engine is idle. The bench drives the slow-bus timing this block expects: each byte is followed by eight observation cycles before the next strobe, and every mode, bank or command change is made between bytes.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;
  localparam int ROW_N = 4;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MUX2   = 2'd1,
    MODE_MUX3   = 2'd2,
    MODE_MUX4   = 2'd3
  } drive_mode_e;

  // Bits stored per column for a drive mode (1..4).
  function automatic logic [2:0] bits_per_col(input drive_mode_e m);
    return {1'b0, m} + 3'd1;
  endfunction

  // Bank select only relocates the two low-multiplex modes.
  function automatic logic bank_applies(input drive_mode_e m);
    return (m == MODE_STATIC) || (m == MODE_MUX2);
  endfunction
endpackage

// File: rtl/dwr_bit_feed.sv
module dwr_bit_feed #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              step,
  output logic              bit_out
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              en;

  assign step    = (left_q != '0);
  assign bit_out = sh_q[BYTE_W-1];
  assign en      = load || step;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = din;
      left_d = CNT_W'(BYTE_W);
    end else if (step) begin
      sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/dwr_col_track.sv
module dwr_col_track
  import disp_wr_pkg::*;
#(
  parameter int COLS  = 80,
  parameter int SUB_W = 3,
  localparam int PTR_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  drive_mode_e      mode,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             dev_sel,
  input  logic [SUB_W-1:0] dev_val,
  output logic [PTR_W-1:0] ptr,
  output logic [1:0]       phase,
  output logic [SUB_W-1:0] sub
);
  logic [PTR_W-1:0] ptr_d;
  logic [1:0]       phase_d;
  logic [SUB_W-1:0] sub_d;
  logic             group_done, at_last, ptr_en, sub_en;

  assign group_done = ({1'b0, phase} == (bits_per_col(mode) - 3'd1));
  assign at_last    = (ptr == PTR_W'(COLS - 1));
  assign ptr_en     = ptr_load || step;
  assign sub_en     = dev_sel || (step && group_done && at_last);

  always_comb begin
    ptr_d   = ptr;
    phase_d = phase;
    if (ptr_load) begin
      ptr_d   = ({1'b0, ptr_val} < (PTR_W + 1)'(COLS)) ? ptr_val : '0;
      phase_d = '0;
    end else if (step) begin
      if (group_done) begin
        phase_d = '0;
        ptr_d   = at_last ? '0 : ptr + 1'b1;
      end else begin
        phase_d = phase + 1'b1;
      end
    end
  end

  always_comb begin
    sub_d = sub;
    if (dev_sel)
      sub_d = dev_val;
    else if (step && group_done && at_last)
      sub_d = sub + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      phase <= '0;
    end else if (ptr_en) begin
      ptr   <= ptr_d;
      phase <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sub <= '0;
    else if (sub_en)
      sub <= sub_d;
  end
endmodule

// File: rtl/dwr_write_out.sv
module dwr_write_out
  import disp_wr_pkg::*;
#(
  parameter int PTR_W = 7,
  parameter int SUB_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             bit_in,
  input  drive_mode_e      mode,
  input  logic             bank,
  input  logic [1:0]       phase,
  input  logic [PTR_W-1:0] ptr,
  input  logic [SUB_W-1:0] sub,
  input  logic [SUB_W-1:0] hw_sub,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [ROW_N-1:0] wr_mask,
  output logic [ROW_N-1:0] wr_data
);
  logic [1:0]       row;
  logic             en_d;
  logic [ROW_N-1:0] mask_d, data_d;

  always_comb begin
    row    = phase + ((bank && bank_applies(mode)) ? 2'd2 : 2'd0);
    mask_d = ROW_N'(1) << row;
    data_d = bit_in ? mask_d : '0;
    en_d   = step && (sub == hw_sub);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wr_en <= 1'b0;
    else
      wr_en <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_mask <= '0;
      wr_data <= '0;
    end else if (step) begin
      wr_addr <= ptr;
      wr_mask <= mask_d;
      wr_data <= data_d;
    end
  end
endmodule

// File: rtl/disp_ram_writer.sv
module disp_ram_writer
  import disp_wr_pkg::*;
#(
  parameter int COLS   = 80,
  parameter int SUB_W  = 3,
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SUB_W-1:0]  hw_sub,
  input  logic              dev_sel,
  input  logic [SUB_W-1:0]  dev_val,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_val,
  input  logic [1:0]        drive_mode,
  input  logic              in_bank,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [ROW_N-1:0]  wr_mask,
  output logic [ROW_N-1:0]  wr_data
);
  drive_mode_e      mode;
  logic             step, bit_cur;
  logic [PTR_W-1:0] ptr;
  logic [1:0]       phase;
  logic [SUB_W-1:0] sub;

  assign mode = drive_mode_e'(drive_mode);

  dwr_bit_feed #(.BYTE_W(BYTE_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .load(byte_valid), .din(byte_data),
    .step(step), .bit_out(bit_cur)
  );

  dwr_col_track #(.COLS(COLS), .SUB_W(SUB_W)) u_track (
    .clk(clk), .rst_n(rst_n), .step(step), .mode(mode),
    .ptr_load(ptr_load), .ptr_val(ptr_val),
    .dev_sel(dev_sel), .dev_val(dev_val),
    .ptr(ptr), .phase(phase), .sub(sub)
  );

  dwr_write_out #(.PTR_W(PTR_W), .SUB_W(SUB_W)) u_out (
    .clk(clk), .rst_n(rst_n), .step(step), .bit_in(bit_cur),
    .mode(mode), .bank(in_bank), .phase(phase), .ptr(ptr),
    .sub(sub), .hw_sub(hw_sub),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data)
  );
endmodule

// File: rtl/disp_ram_writer_chk.sv
module disp_ram_writer_chk #(
  parameter int COLS  = 80,
  parameter int SUB_W = 3,
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [PTR_W-1:0] wr_addr,
  input logic [3:0]       wr_mask,
  input logic [3:0]       wr_data,
  input logic [1:0]       drive_mode,
  input logic             in_bank,
  input logic             dev_sel,
  input logic             ptr_load,
  input logic             step,
  input logic [PTR_W-1:0] ptr,
  input logic [1:0]       phase,
  input logic [SUB_W-1:0] sub
);
  logic last_bit_of_col;
  assign last_bit_of_col = ({1'b0, phase} == {1'b0, drive_mode})
                           && (ptr == PTR_W'(COLS - 1));

  // R2: exactly one row is touched per write
  assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_mask) == 1));

  // R2: data never leaks outside the selected row
  assert_data_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~wr_mask) == 4'b0000));

  // R2: with the feed idle no write is issued in the next cycle
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !wr_en);

  // R7: banked static mode always lands in row 2
  assert_bank_static_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && drive_mode == 2'd0 && in_bank) |=> (wr_mask == 4'b0100));

  // R9: finishing the last column bumps the subaddress counter
  assert_sub_bump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_bit_of_col && !dev_sel && !ptr_load)
      |=> (sub == $past(sub) + 1'b1) && (ptr == '0));

  // R12: the presented column is always inside the RAM
  assert_addr_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < (PTR_W + 1)'(COLS)));
endmodule

bind disp_ram_writer disp_ram_writer_chk #(.COLS(COLS), .SUB_W(SUB_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_mask(wr_mask), .wr_data(wr_data), .drive_mode(drive_mode),
  .in_bank(in_bank), .dev_sel(dev_sel), .ptr_load(ptr_load),
  .step(step), .ptr(ptr), .phase(phase), .sub(sub)
);

// File: tb/test_disp_ram_writer.sv
module test_disp_ram_writer;
  localparam int COLS = 80;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hw_sub = '0, dev_val = '0;
  logic       dev_sel = 1'b0, ptr_load = 1'b0, in_bank = 1'b0, byte_valid = 1'b0;
  logic [6:0] ptr_val = '0;
  logic [1:0] drive_mode = '0;
  logic [7:0] byte_data = '0;
  logic       wr_en;
  logic [6:0] wr_addr;
  logic [3:0] wr_mask, wr_data;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int m_ptr, m_phase, m_sub;

  always #10 clk = ~clk;

  disp_ram_writer i_disp_ram_writer (
    .clk(clk), .rst_n(rst_n), .hw_sub(hw_sub), .dev_sel(dev_sel),
    .dev_val(dev_val), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .drive_mode(drive_mode), .in_bank(in_bank), .byte_valid(byte_valid),
    .byte_data(byte_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_mask(wr_mask), .wr_data(wr_data)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       bank;
    logic [2:0] hw;
    logic [2:0] dev;
    logic [6:0] ptr;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 3'd0, 3'd0, 7'd5,  8'hA5},
    '{2'd0, 1'b1, 3'd2, 3'd2, 7'd10, 8'h3C},
    '{2'd1, 1'b0, 3'd1, 3'd1, 7'd0,  8'hC9},
    '{2'd1, 1'b1, 3'd1, 3'd1, 7'd20, 8'h96},
    '{2'd2, 1'b0, 3'd3, 3'd3, 7'd40, 8'hF0},
    '{2'd3, 1'b1, 3'd4, 3'd4, 7'd79, 8'hE7},
    '{2'd3, 1'b0, 3'd5, 3'd3, 7'd2,  8'h5A},
    '{2'd2, 1'b1, 3'd6, 3'd6, 7'd7,  8'h81}
  };

  task automatic report(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmd_dev(input logic [2:0] v);
    @(negedge clk); dev_sel = 1'b1; dev_val = v;
    @(negedge clk); dev_sel = 1'b0;
    m_sub = v;
  endtask

  task automatic cmd_ptr(input logic [6:0] v);
    @(negedge clk); ptr_load = 1'b1; ptr_val = v;
    @(negedge clk); ptr_load = 1'b0;
    m_ptr = (v < COLS) ? int'(v) : 0;
    m_phase = 0;
  endtask

  // Compare the write presented now against the reference, then advance it.
  task automatic check_bit(input string tag, input logic b);
    int row, bpc;
    logic exp_en;
    bpc = int'(drive_mode) + 1;
    row = m_phase + ((in_bank && drive_mode < 2) ? 2 : 0);
    exp_en = (m_sub == int'(hw_sub));
    report(tag, "wr_en", int'(wr_en), int'(exp_en));
    if (exp_en) begin
      report(tag, "wr_addr", int'(wr_addr), m_ptr);
      report(tag, "wr_mask", int'(wr_mask), 1 << row);
      report(tag, "wr_data", int'(wr_data), b ? (1 << row) : 0);
    end
    if (m_phase == bpc - 1) begin
      m_phase = 0;
      if (m_ptr == COLS - 1) begin
        m_ptr = 0;
        m_sub = (m_sub + 1) % 8;
      end else begin
        m_ptr++;
      end
    end else begin
      m_phase++;
    end
  endtask

  task automatic send_byte(input string tag, input logic [7:0] d);
    @(negedge clk); byte_valid = 1'b1; byte_data = d;
    @(negedge clk); byte_valid = 1'b0;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      check_bit(tag, d[7 - n]);
    end
  endtask

  task automatic setup(input logic [1:0] mode, input logic bank, input logic [2:0] hw);
    @(negedge clk); drive_mode = mode; in_bank = bank; hw_sub = hw;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    m_ptr = 0; m_phase = 0; m_sub = 0;
    repeat (3) @(negedge clk);
    report("R1", "wr_en in reset", int'(wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    report("R1", "wr_en after reset", int'(wr_en), 0);
    // R1: no commands; reset pointer 0 and subaddress 0 must match hw 0
    setup(2'd0, 1'b0, 3'd0);
    send_byte("R1", 8'h80);
    @(negedge clk);
    report("R2", "wr_en idle after byte", int'(wr_en), 0);

    // table walk: R2 R3 R4 R6 R7 R8 R9 R11
    foreach (VECS[i]) begin
      setup(VECS[i].mode, VECS[i].bank, VECS[i].hw);
      cmd_dev(VECS[i].dev);
      cmd_ptr(VECS[i].ptr);
      send_byte(i == 5 ? "R9" : (i == 6 ? "R8" : "R7"), VECS[i].data);
    end

    // R5: 1:3 group spans two bytes
    setup(2'd2, 1'b0, 3'd2);
    cmd_dev(3'd2); cmd_ptr(7'd50);
    send_byte("R5", 8'hB6);
    send_byte("R5", 8'h4D);
    report("R5", "phase carried", m_phase, 1);

    // R9: static handover mid-byte, hw 1 takes columns after wrap
    setup(2'd0, 1'b0, 3'd1);
    cmd_dev(3'd0); cmd_ptr(7'd77);
    send_byte("R9", 8'hD3);
    report("R9", "model sub after wrap", m_sub, 1);

    // R10: counter 7 wraps to 0
    setup(2'd0, 1'b0, 3'd0);
    cmd_dev(3'd7); cmd_ptr(7'd78);
    send_byte("R10", 8'h6E);

    // R11: pointer load restarts the row phase in 1:3 mode
    setup(2'd2, 1'b0, 3'd3);
    cmd_dev(3'd3); cmd_ptr(7'd12);
    send_byte("R11", 8'hFF);
    cmd_ptr(7'd30);
    send_byte("R11", 8'h9C);

    // R12: out-of-range pointer load lands on column 0
    setup(2'd1, 1'b0, 3'd4);
    cmd_dev(3'd4); cmd_ptr(7'd100);
    send_byte("R12", 8'hA1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule